// File: doc/BRIEF.md
# Double-Precision Multiply Rounding and Exception Stage

This block surrounds an IEEE 754 binary64 significand multiplier. It takes two 64-bit operands and unpacks each one. A subnormal operand is normalized, and the unpacked significands are presented on two output ports. An external multiplier returns their full 106-bit product on `prod_i` within the same cycle. From that product the block forms the result sign and exponent, and it handles NaN, infinity and zero operands. It rounds under a selected mode and detects overflow and underflow.

For every accepted operation the block raises exception flags or trap indications. The registered result appears one clock after `in_valid_i`. The caller's accumulated status flags enter on `flags_i`. They leave on `flags_o`, merged with any newly raised flags.

When an overflow or underflow trap is enabled, the block does not saturate or denormalize the result. It delivers the result with its exponent wrapped by 1536. Tininess is judged after rounding.

Top module: `fpmul_round_stage`

## Requirements
- R1: The result of an accepted operation appears on `res_o` one clock after `in_valid_i`, with `done_o` high for that cycle. The result sign is the XOR of the operand signs (bit 63), for example 2.0 x 3.0 = 0x4018000000000000 and -1.5 x 2.0 = 0xC008000000000000.
- R2: A zero operand times a finite number gives a zero whose sign is the XOR of the operand signs, and raises no flag.
- R3: Infinity times zero, in either order, is invalid. It delivers 0x7FF8000000000000 and sets the invalid flag (bit 3 of the flag, trap and enable vectors). With the invalid trap enabled it asserts `trap_o[3]`, `res_we_o` stays low and no flag is raised. Infinity times a nonzero non-NaN value gives a signed infinity.
- R4: A signaling NaN (exponent all ones, fraction MSB 0, fraction nonzero) in operand A has priority over one in operand B. The selected NaN is returned with fraction bit 51 set, and invalid is raised. If neither operand is signaling, a quiet NaN in A, then one in B, is returned unchanged with no flag.
- R5: A subnormal operand is normalized so that bit 52 of its `sig_*_o` is set. Its effective biased exponent is 1 minus the shift. The result exponent is expA + expB - 1023, plus 1 when the product is 2 or more.
- R6: Rounding-mode encoding: 0 is to nearest-even, 1 is truncation, 2 is toward +infinity and 3 is toward -infinity. Mode 2 increments inexact positive results and mode 3 increments inexact negative results.
- R7: In nearest mode the result is incremented when guard is set and either sticky or the LSB is set. A carry out of the significand increments the exponent.
- R8: If the exponent reaches 2047 and the overflow trap is disabled, the overflow and inexact flags (bits 2 and 0) are raised. Mode 0 gives infinity. Mode 2 gives infinity for positive results and mode 3 gives infinity for negative results. Every other case gives the largest finite value of the result sign.
- R9: With the overflow trap enabled, an overflowing result is delivered with exponent minus 1536 and `trap_o[2]` set.
- R10: If the exponent is 0 or less and the underflow trap is disabled, the significand is shifted right into subnormal form. Guard and sticky are recomputed and the mode rules are applied again. Underflow (bit 1) is raised only if the result is both tiny and inexact. An exact subnormal result raises nothing.
- R11: At exponent 0 with an inexact product, a trial rounding that carries out of an all-ones significand marks the result as not tiny. Only inexact is raised.
- R12: With the underflow trap enabled, an underflowing result is rounded and delivered with exponent plus 1536 and `trap_o[1]` set.
- R13: An inexact result asserts `trap_o[0]` if the inexact trap is enabled, still writing the result, and otherwise sets inexact. `flags_o` becomes `flags_i` ORed with the raised flags on each operation and holds when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation accepted this cycle |
| op_a_i | input | 64 | Operand A, binary64 |
| op_b_i | input | 64 | Operand B, binary64 |
| rmode_i | input | 2 | Rounding mode (0 nearest, 1 truncate, 2 up, 3 down) |
| trap_en_i | input | 4 | Trap enables {invalid, overflow, underflow, inexact} |
| flags_i | input | 4 | Accumulated status flags, same bit order |
| sig_a_o | output | 53 | Normalized significand of A, to the multiplier |
| sig_b_o | output | 53 | Normalized significand of B, to the multiplier |
| prod_i | input | 106 | Product sig_a_o x sig_b_o from the multiplier |
| done_o | output | 1 | Result cycle of an operation |
| res_we_o | output | 1 | Result is valid for writing |
| res_o | output | 64 | Result, binary64 or wrapped-exponent form |
| trap_o | output | 4 | Traps signalled, same bit order as flags |
| flags_o | output | 4 | Updated status flags |

## Verification
The hardest condition to reach is a result whose pre-round exponent is exactly 0 and whose significand is all ones with guard and sticky set. Only there does the trial rounding decide tininess. The bench reaches it with operand significands 1+2^-52 and 2-2^-51, whose exact product is 2^105-2. The operand exponents are chosen to sum to 1023. The same pair run at a normal exponent exercises the carry into the exponent. The test then repeats with truncation, where the result must instead be tiny.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int unsigned EXP_W  = 11;
    localparam int unsigned FRAC_W = 52;
    localparam int unsigned SIG_W  = FRAC_W + 1;
    localparam int unsigned PROD_W = 2 * SIG_W;
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
    localparam int unsigned EXP_IW = EXP_W + 3;
    localparam int unsigned NFLAG  = 4;

    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam int WRAP    = 3 << (EXP_W - 2);

    localparam int F_INV = 3;
    localparam int F_OVF = 2;
    localparam int F_UNF = 1;
    localparam int F_INX = 0;

    typedef logic signed [EXP_IW-1:0] sexp_t;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_t;

    typedef struct packed {
        logic              sign;
        logic              zero;
        logic              inf;
        logic              nan;
        logic              snan;
        logic [FRAC_W-1:0] frac;
        logic [SIG_W-1:0]  sig;
        sexp_t             exp;
    } opnd_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output opnd_t             opnd_o
);
    localparam int LZ_W = $clog2(SIG_W + 1);

    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    logic [SIG_W-1:0]  raw;
    logic [LZ_W-1:0]   lz;

    always_comb begin
        e   = word_i[WORD_W-2 -: EXP_W];
        f   = word_i[FRAC_W-1:0];
        raw = {1'b0, f};
        lz  = '0;
        // the highest set bit wins, since it is visited last
        for (int i = 0; i < int'(SIG_W); i++) begin
            if (raw[i]) lz = LZ_W'(int'(SIG_W) - 1 - i);
        end
        opnd_o.sign = word_i[WORD_W-1];
        opnd_o.frac = f;
        opnd_o.zero = (e == '0) && (f == '0);
        opnd_o.inf  = (&e) && (f == '0);
        opnd_o.nan  = (&e) && (f != '0);
        opnd_o.snan = (&e) && (f != '0) && !f[FRAC_W-1];
        if (e != '0) begin
            opnd_o.sig = {1'b1, f};
            opnd_o.exp = sexp_t'({{(EXP_IW-EXP_W){1'b0}}, e});
        end else begin
            opnd_o.sig = raw << lz;
            opnd_o.exp = sexp_t'(1) - sexp_t'({{(EXP_IW-LZ_W){1'b0}}, lz});
        end
    end
endmodule

// File: rtl/fpm_round_inc.sv
module fpm_round_inc
    import fpm_pkg::*;
(
    input  rmode_t mode_i,
    input  logic   sign_i,
    input  logic   lsb_i,
    input  logic   guard_i,
    input  logic   sticky_i,
    output logic   inc_o
);
    always_comb begin
        unique case (mode_i)
            RM_NEAR: inc_o = guard_i && (sticky_i || lsb_i);
            RM_UP:   inc_o = !sign_i && (guard_i || sticky_i);
            RM_DOWN: inc_o = sign_i && (guard_i || sticky_i);
            default: inc_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpm_denorm.sv
module fpm_denorm
    import fpm_pkg::*;
(
    input  logic [SIG_W-1:0] sig_i,
    input  logic             guard_i,
    input  logic             sticky_i,
    input  sexp_t            exp_i,
    output logic [SIG_W-1:0] sig_o,
    output logic             guard_o,
    output logic             sticky_o
);
    localparam int PAD    = SIG_W + 2;
    localparam int WIDE   = SIG_W + 1 + PAD;
    localparam int SH_MAX = PAD + 1;
    localparam int SH_W   = $clog2(SH_MAX + 1);

    sexp_t           amt;
    logic [SH_W-1:0] sh;
    logic [WIDE-1:0] wide;

    always_comb begin
        amt = sexp_t'(1) - exp_i;
        if (amt > sexp_t'(SH_MAX))  sh = SH_W'(SH_MAX);
        else if (amt < sexp_t'(0))  sh = '0;
        else                        sh = amt[SH_W-1:0];
        wide     = {sig_i, guard_i, {PAD{1'b0}}} >> sh;
        sig_o    = wide[WIDE-1 -: SIG_W];
        guard_o  = wide[PAD];
        sticky_o = (|wide[PAD-1:0]) || sticky_i;
    end
endmodule

// File: rtl/fpmul_round_stage.sv
module fpmul_round_stage
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [63:0]       op_a_i,
    input  logic [63:0]       op_b_i,
    input  logic [1:0]        rmode_i,
    input  logic [3:0]        trap_en_i,
    input  logic [3:0]        flags_i,
    output logic [52:0]       sig_a_o,
    output logic [52:0]       sig_b_o,
    input  logic [105:0]      prod_i,
    output logic              done_o,
    output logic              res_we_o,
    output logic [63:0]       res_o,
    output logic [3:0]        trap_o,
    output logic [3:0]        flags_o
);
    localparam logic [WORD_W-1:0] QNAN_DEF =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-2:0] MAX_MAG =
        {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    localparam logic [WORD_W-2:0] INF_MAG =
        {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic              done;
        logic              we;
        logic [WORD_W-1:0] res;
        logic [NFLAG-1:0]  trap;
        logic [NFLAG-1:0]  flags;
    } state_t;

    state_t st_d, st_q;

    // operand unpacking, one per operand
    logic [WORD_W-1:0] words [2];
    opnd_t             opnd  [2];
    assign words[0] = op_a_i;
    assign words[1] = op_b_i;

    for (genvar k = 0; k < 2; k++) begin : g_unpack
        fpm_unpack u_unpack (.word_i(words[k]), .opnd_o(opnd[k]));
    end

    assign sig_a_o = opnd[0].sig;
    assign sig_b_o = opnd[1].sig;

    // product alignment and first rounding
    rmode_t           rm;
    logic             sgn, hi, grd, stk, inx0, inc_n, do_rnd;
    logic [SIG_W-1:0] mant, mant_r;
    logic [SIG_W:0]   sum;
    sexp_t            dexp, exp1, exp2;

    always_comb begin
        rm   = rmode_t'(rmode_i);
        sgn  = opnd[0].sign ^ opnd[1].sign;
        dexp = opnd[0].exp + opnd[1].exp - sexp_t'(BIAS);
        hi   = prod_i[PROD_W-1];
        if (hi) begin
            mant = prod_i[PROD_W-1 -: SIG_W];
            grd  = prod_i[PROD_W-1-SIG_W];
            stk  = |prod_i[PROD_W-2-SIG_W:0];
        end else begin
            mant = prod_i[PROD_W-2 -: SIG_W];
            grd  = prod_i[PROD_W-2-SIG_W];
            stk  = |prod_i[PROD_W-3-SIG_W:0];
        end
        exp1   = dexp + sexp_t'({{(EXP_IW-1){1'b0}}, hi});
        inx0   = grd || stk;
        do_rnd = inx0 && ((exp1 > sexp_t'(0)) || trap_en_i[F_UNF]);
        sum    = {1'b0, mant} + {{SIG_W{1'b0}}, do_rnd && inc_n};
        mant_r = sum[SIG_W] ? sum[SIG_W:1] : sum[SIG_W-1:0];
        exp2   = exp1 + sexp_t'({{(EXP_IW-1){1'b0}}, sum[SIG_W]});
    end

    fpm_round_inc u_rnd_norm (
        .mode_i(rm), .sign_i(sgn), .lsb_i(mant[0]),
        .guard_i(grd), .sticky_i(stk), .inc_o(inc_n)
    );

    // subnormal path: shift, recompute guard and sticky, round again
    logic [SIG_W-1:0] dm, dres;
    logic             dg, ds, inc_d, inx2, not_tiny;

    fpm_denorm u_denorm (
        .sig_i(mant), .guard_i(grd), .sticky_i(stk), .exp_i(exp2),
        .sig_o(dm), .guard_o(dg), .sticky_o(ds)
    );

    fpm_round_inc u_rnd_sub (
        .mode_i(rm), .sign_i(sgn), .lsb_i(dm[0]),
        .guard_i(dg), .sticky_i(ds), .inc_o(inc_d)
    );

    always_comb begin
        dres     = dm + {{(SIG_W-1){1'b0}}, inc_d};
        inx2     = dg || ds;
        // tininess after rounding: the trial increment would carry out
        not_tiny = (exp1 == sexp_t'(0)) && inx0 && inc_n && (&mant);
    end

    // result selection and exception resolution
    logic                any_nan, any_snan, inv, inx, sat_inf;
    logic [NFLAG-1:0]    raise, tr;
    logic [WORD_W-1:0]   res;
    logic [FRAC_W-1:0]   nan_frac;
    logic                nan_sign;
    sexp_t               wexp;

    always_comb begin
        any_nan  = opnd[0].nan || opnd[1].nan;
        any_snan = opnd[0].snan || opnd[1].snan;
        inv      = 1'b0;
        inx      = 1'b0;
        raise    = '0;
        tr       = '0;
        res      = '0;
        wexp     = '0;
        nan_sign = opnd[1].sign;
        nan_frac = opnd[1].frac;
        sat_inf  = (rm == RM_NEAR) || (rm == RM_UP && !sgn) || (rm == RM_DOWN && sgn);

        if (any_nan) begin
            if (opnd[0].snan || (opnd[0].nan && !opnd[1].snan)) begin
                nan_sign = opnd[0].sign;
                nan_frac = opnd[0].frac;
            end
            inv = any_snan;
            res = {nan_sign, {EXP_W{1'b1}}, 1'b1, nan_frac[FRAC_W-2:0]};
        end else if (opnd[0].inf || opnd[1].inf) begin
            if (opnd[0].zero || opnd[1].zero) begin
                inv = 1'b1;
                res = QNAN_DEF;
            end else begin
                res = {sgn, INF_MAG};
            end
        end else if (opnd[0].zero || opnd[1].zero) begin
            res = {sgn, {(WORD_W-1){1'b0}}};
        end else if (exp2 >= sexp_t'(EXP_TOP)) begin
            if (trap_en_i[F_OVF]) begin
                tr[F_OVF] = 1'b1;
                wexp      = exp2 - sexp_t'(WRAP);
                res       = {sgn, wexp[EXP_W-1:0], mant_r[FRAC_W-1:0]};
                inx       = inx0;
            end else begin
                raise[F_OVF] = 1'b1;
                res          = {sgn, sat_inf ? INF_MAG : MAX_MAG};
                inx          = 1'b1;
            end
        end else if (exp2 <= sexp_t'(0)) begin
            if (trap_en_i[F_UNF]) begin
                tr[F_UNF] = 1'b1;
                wexp      = exp2 + sexp_t'(WRAP);
                res       = {sgn, wexp[EXP_W-1:0], mant_r[FRAC_W-1:0]};
                inx       = inx0;
            end else begin
                res          = {sgn, {(EXP_W-1){1'b0}}, dres};
                inx          = inx2;
                raise[F_UNF] = inx2 && !not_tiny;
            end
        end else begin
            res = {sgn, exp2[EXP_W-1:0], mant_r[FRAC_W-1:0]};
            inx = inx0;
        end

        if (inv) begin
            if (trap_en_i[F_INV]) begin
                tr[F_INV] = 1'b1;
                res       = '0;
            end else begin
                raise[F_INV] = 1'b1;
            end
        end
        if (inx) begin
            if (trap_en_i[F_INX]) tr[F_INX] = 1'b1;
            else                  raise[F_INX] = 1'b1;
        end
    end

    // next-state
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = 1'b0;
        st_d.trap = '0;
        if (in_valid_i) begin
            st_d.done  = 1'b1;
            st_d.we    = !tr[F_INV];
            st_d.res   = res;
            st_d.trap  = tr;
            st_d.flags = flags_i | raise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign res_we_o = st_q.we;
    assign res_o    = st_q.res;
    assign trap_o   = st_q.trap;
    assign flags_o  = st_q.flags;

    // R1
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> done_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!done_o && !res_we_o && trap_o == '0));

    // R3
    inv_trap_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && trap_o[F_INV]) |-> !res_we_o);

    // R9
    wrap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(trap_o[F_OVF] && trap_o[F_UNF]));

    // R13
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> ((flags_o & $past(flags_i)) == $past(flags_i)));

    // R13
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(flags_o));
endmodule

// File: tb/fpmul_round_stage_tb.sv
module fpmul_round_stage_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  op_a = '0, op_b = '0;
    logic [1:0]   rmode = '0;
    logic [3:0]   ten = '0, fin = '0;
    logic [52:0]  sig_a, sig_b;
    logic [105:0] prod;
    logic         done, we;
    logic [63:0]  res;
    logic [3:0]   trap, flags;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // stands in for the external significand multiplier
    assign prod = {{53{1'b0}}, sig_a} * {{53{1'b0}}, sig_b};

    fpmul_round_stage u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid),
        .op_a_i(op_a), .op_b_i(op_b), .rmode_i(rmode),
        .trap_en_i(ten), .flags_i(fin),
        .sig_a_o(sig_a), .sig_b_o(sig_b), .prod_i(prod),
        .done_o(done), .res_we_o(we), .res_o(res),
        .trap_o(trap), .flags_o(flags)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] rm, input logic [3:0] te, input logic [3:0] fi,
                          input logic [63:0] eres, input logic ewe,
                          input logic [3:0] etrap, input logic [3:0] eflags);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; rmode = rm; ten = te; fin = fi;
        @(negedge clk);
        in_valid = 1'b0; fin = '0; ten = '0;
        chk(req, "done", 64'(done), 64'd1);
        chk(req, "we", 64'(we), 64'(ewe));
        if (ewe) chk(req, "res", res, eres);
        chk(req, "trap", 64'(trap), 64'(etrap));
        chk(req, "flags", 64'(flags), 64'(eflags));
    endtask

    task automatic t_reset();
        chk("R1", "reset done", 64'(done), 64'd0);
        chk("R1", "reset we", 64'(we), 64'd0);
        chk("R13", "reset flags", 64'(flags), 64'd0);
        chk("R13", "reset trap", 64'(trap), 64'd0);
    endtask

    task automatic t_basic();
        run_op("R1", 64'h4000000000000000, 64'h4008000000000000, 2'd0, 4'h0, 4'h0,
               64'h4018000000000000, 1'b1, 4'h0, 4'h0);
        run_op("R1", 64'hBFF8000000000000, 64'h4000000000000000, 2'd0, 4'h0, 4'h0,
               64'hC008000000000000, 1'b1, 4'h0, 4'h0);
        @(negedge clk);
        chk("R1", "done drops", 64'(done), 64'd0);
    endtask

    task automatic t_zero();
        run_op("R2", 64'h0000000000000000, 64'hC014000000000000, 2'd0, 4'h0, 4'h0,
               64'h8000000000000000, 1'b1, 4'h0, 4'h0);
    endtask

    task automatic t_invalid();
        run_op("R3", 64'h7FF0000000000000, 64'h8000000000000000, 2'd0, 4'h0, 4'h0,
               64'h7FF8000000000000, 1'b1, 4'h0, 4'h8);
        run_op("R3", 64'h0000000000000000, 64'hFFF0000000000000, 2'd0, 4'h8, 4'h0,
               64'h0, 1'b0, 4'h8, 4'h0);
        run_op("R3", 64'hFFF0000000000000, 64'h4000000000000000, 2'd0, 4'h0, 4'h0,
               64'hFFF0000000000000, 1'b1, 4'h0, 4'h0);
    endtask

    task automatic t_nan();
        run_op("R4", 64'h7FF0000000000001, 64'hFFF0000000000002, 2'd0, 4'h0, 4'h0,
               64'h7FF8000000000001, 1'b1, 4'h0, 4'h8);
        run_op("R4", 64'h7FF8000000000005, 64'hFFF0000000000002, 2'd0, 4'h0, 4'h0,
               64'hFFF8000000000002, 1'b1, 4'h0, 4'h8);
        run_op("R4", 64'h7FF0000000000000, 64'h7FF8000000000007, 2'd0, 4'h0, 4'h0,
               64'h7FF8000000000007, 1'b1, 4'h0, 4'h0);
        run_op("R4", 64'hFFF8000000000003, 64'h0000000000000000, 2'd0, 4'h0, 4'h0,
               64'hFFF8000000000003, 1'b1, 4'h0, 4'h0);
    endtask

    task automatic t_denorm_in();
        @(negedge clk);
        op_a = 64'h0000000000000001; op_b = 64'h43B0000000000000;
        #1;
        chk("R5", "sig_a normalized", 64'(sig_a), 64'h0010000000000000);
        run_op("R5", 64'h0000000000000001, 64'h43B0000000000000, 2'd0, 4'h0, 4'h0,
               64'h0090000000000000, 1'b1, 4'h0, 4'h0);
    endtask

    task automatic t_directed();
        run_op("R6", 64'h3FF0000000000001, 64'h3FF0000000000001, 2'd2, 4'h0, 4'h0,
               64'h3FF0000000000003, 1'b1, 4'h0, 4'h1);
        run_op("R6", 64'h3FF0000000000001, 64'h3FF0000000000001, 2'd3, 4'h0, 4'h0,
               64'h3FF0000000000002, 1'b1, 4'h0, 4'h1);
        run_op("R6", 64'hBFF0000000000001, 64'h3FF0000000000001, 2'd3, 4'h0, 4'h0,
               64'hBFF0000000000003, 1'b1, 4'h0, 4'h1);
        run_op("R6", 64'hBFF0000000000001, 64'h3FF0000000000001, 2'd2, 4'h0, 4'h0,
               64'hBFF0000000000002, 1'b1, 4'h0, 4'h1);
    endtask

    task automatic t_nearest();
        run_op("R7", 64'h3FF0000000000001, 64'h3FF0000000000001, 2'd0, 4'h0, 4'h0,
               64'h3FF0000000000002, 1'b1, 4'h0, 4'h1);
        run_op("R7", 64'h3FF0000000000001, 64'h3FF8000000000000, 2'd0, 4'h0, 4'h0,
               64'h3FF8000000000002, 1'b1, 4'h0, 4'h1);
        run_op("R7", 64'h3FF0000000000003, 64'h3FF8000000000000, 2'd0, 4'h0, 4'h0,
               64'h3FF8000000000004, 1'b1, 4'h0, 4'h1);
        run_op("R7", 64'h3FF0000000000001, 64'h3FFFFFFFFFFFFFFE, 2'd0, 4'h0, 4'h0,
               64'h4000000000000000, 1'b1, 4'h0, 4'h1);
    endtask

    task automatic t_overflow();
        run_op("R8", 64'h7FE0000000000000, 64'h4000000000000000, 2'd0, 4'h0, 4'h0,
               64'h7FF0000000000000, 1'b1, 4'h0, 4'h5);
        run_op("R8", 64'h7FE0000000000000, 64'h4000000000000000, 2'd1, 4'h0, 4'h0,
               64'h7FEFFFFFFFFFFFFF, 1'b1, 4'h0, 4'h5);
        run_op("R8", 64'hFFE0000000000000, 64'h4000000000000000, 2'd2, 4'h0, 4'h0,
               64'hFFEFFFFFFFFFFFFF, 1'b1, 4'h0, 4'h5);
        run_op("R8", 64'hFFE0000000000000, 64'h4000000000000000, 2'd3, 4'h0, 4'h0,
               64'hFFF0000000000000, 1'b1, 4'h0, 4'h5);
    endtask

    task automatic t_ovf_trap();
        run_op("R9", 64'h7FE0000000000000, 64'h4000000000000000, 2'd0, 4'h4, 4'h0,
               64'h1FF0000000000000, 1'b1, 4'h4, 4'h0);
    endtask

    task automatic t_underflow();
        run_op("R10", 64'h0010000000000000, 64'h3FE0000000000000, 2'd0, 4'h0, 4'h0,
               64'h0008000000000000, 1'b1, 4'h0, 4'h0);
        run_op("R10", 64'h0010000000000001, 64'h3FE0000000000000, 2'd0, 4'h0, 4'h0,
               64'h0008000000000000, 1'b1, 4'h0, 4'h3);
        run_op("R10", 64'h0010000000000001, 64'h3FE0000000000000, 2'd2, 4'h0, 4'h0,
               64'h0008000000000001, 1'b1, 4'h0, 4'h3);
    endtask

    task automatic t_tiny();
        run_op("R11", 64'h0010000000000001, 64'h3FEFFFFFFFFFFFFE, 2'd0, 4'h0, 4'h0,
               64'h0010000000000000, 1'b1, 4'h0, 4'h1);
        run_op("R11", 64'h0010000000000001, 64'h3FEFFFFFFFFFFFFE, 2'd1, 4'h0, 4'h0,
               64'h000FFFFFFFFFFFFF, 1'b1, 4'h0, 4'h3);
    endtask

    task automatic t_unf_trap();
        run_op("R12", 64'h0010000000000000, 64'h3FE0000000000000, 2'd0, 4'h2, 4'h0,
               64'h6000000000000000, 1'b1, 4'h2, 4'h0);
    endtask

    task automatic t_inexact_and_sticky();
        run_op("R13", 64'h3FF0000000000001, 64'h3FF0000000000001, 2'd0, 4'h1, 4'h0,
               64'h3FF0000000000002, 1'b1, 4'h1, 4'h0);
        run_op("R13", 64'h4000000000000000, 64'h4008000000000000, 2'd0, 4'h0, 4'h8,
               64'h4018000000000000, 1'b1, 4'h0, 4'h8);
        @(negedge clk);
        @(negedge clk);
        chk("R13", "flags held idle", 64'(flags), 64'h8);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_zero();
        t_invalid();
        t_nan();
        t_denorm_in();
        t_directed();
        t_nearest();
        t_overflow();
        t_ovf_trap();
        t_underflow();
        t_tiny();
        t_unf_trap();
        t_inexact_and_sticky();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule